// File: doc/BRIEF.md
# Serial Peripheral Data Register with Live Shifter

This block is the byte-wide data path of a serial peripheral port. One CPU-facing register sends and receives. A CPU write goes straight into the serial shift register, because there is no transmit buffer. A read returns a separate holding register, which is refreshed only when a full byte has been exchanged. While the next byte is moving, the CPU therefore still sees the last complete byte.

In master mode, writing the register while the port is idle starts a transfer. The block makes a serial clock from the system clock by a fixed division. In slave mode, the block follows an externally driven serial clock, but only while the select line is low. Both modes use the same framing:

- The clock idles low.
- Data moves most significant bit first.
- Input is sampled on the rising (leading) clock edge.
- Output advances on the falling (trailing) clock edge.

Two sticky flags report what happened:

- A completion flag is set when the eighth bit has been shifted.
- A collision flag is set when a write lands in the middle of a transfer.

A colliding write is discarded, so the transfer in flight finishes with its original data. Both flags are cleared by a clear strobe.

Top module: `spi_data_port`

## Requirements
- R1: In master mode, a write while idle loads the byte and starts a transfer. `mosi_out` presents the byte most significant bit first, with each bit stable at the rising edge of `sck_out`.
- R2: `sck_out` idles low. A transfer produces exactly 8 rising edges on `sck_out`, spaced 2*DIV_HALF system clock cycles apart.
- R3: The bits sampled on the rising edges (`miso_in` in master mode, `mosi_in` in slave mode) form the received byte, first bit as the most significant bit. It appears on `rd_data` when the transfer completes. Until then, `rd_data` keeps the previous byte.
- R4: `xfer_done` is set at completion and stays set until `clr_flags` is pulsed.
- R5: A write during a transfer sets `wr_coll` and is otherwise ignored. The transfer completes with the original byte on the serial output, and the received byte is unaffected.
- R6: `clr_flags` clears both flags. A flag-setting event in the same cycle takes precedence over the clear.
- R7: Reset clears both flags and any transfer in progress. It leaves `rd_data` unchanged.
- R8: In slave mode, bits move only on `sck_in` edges seen while `ss_n` is low. `miso_out` presents the loaded byte most significant bit first. `miso_oe` is 1 while `ss_n` is low and 0 while it is high.
- R9: In slave mode, raising `ss_n` before the eighth bit abandons the partial byte: no flag is set, `rd_data` is unchanged, and the next selection starts again from bit 0.
- R10: In slave mode, a write while no bit has been clocked only loads the shifter and does not set `wr_coll`. Once the first rising edge has been seen, a write is a collision.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low reset |
| master_mode | input | 1 | 1 = master, 0 = slave |
| wr_stb | input | 1 | CPU write strobe for the data register |
| wr_data | input | 8 | CPU write byte |
| clr_flags | input | 1 | Clears completion and collision flags |
| rd_data | output | 8 | Last completely received byte |
| xfer_done | output | 1 | Transfer-complete flag |
| wr_coll | output | 1 | Write-collision flag |
| sck_out | output | 1 | Serial clock driven in master mode |
| mosi_out | output | 1 | Serial data out in master mode |
| miso_in | input | 1 | Serial data in for master mode |
| sck_in | input | 1 | External serial clock for slave mode |
| mosi_in | input | 1 | Serial data in for slave mode |
| ss_n | input | 1 | Slave select, active low |
| miso_out | output | 1 | Serial data out for slave mode |
| miso_oe | output | 1 | Output enable for `miso_out` |

## Verification
The assertions assume that `master_mode` changes only while no transfer is running. They also assume that the slave-side pins change slowly compared with the system clock, so each `sck_in` level lasts longer than the synchronizer depth. The stimulus switches mode only between transfers and holds each `sck_in` level for eight system clocks. In slave mode, it changes `mosi_in` only while `sck_in` is low, well ahead of the next rising edge. Collision writes are issued at chosen points inside a transfer, so that a write and a shift edge on the same cycle are never relied upon.

// File: rtl/spi_dr_pkg.sv
`timescale 1ns/1ps
package spi_dr_pkg;
    typedef enum logic [1:0] {
        EDGE_NONE  = 2'd0,
        EDGE_LEAD  = 2'd1,
        EDGE_TRAIL = 2'd2
    } edge_e;
endpackage

// File: rtl/spi_dr_mclk.sv
`timescale 1ns/1ps
module spi_dr_mclk
    import spi_dr_pkg::*;
#(
    parameter int DIV_HALF = 3
) (
    input  logic  clk,
    input  logic  rst_n,
    input  logic  run,
    output logic  sck_o,
    output edge_e edge_o
);
    localparam int DW = $clog2(DIV_HALF + 1);
    localparam logic [DW-1:0] TOP = DW'(DIV_HALF - 1);

    typedef struct packed {
        logic [DW-1:0] div;
        logic          sck;
    } mclk_t;

    mclk_t s_d, s_q;

    always_comb begin
        s_d    = s_q;
        edge_o = EDGE_NONE;
        if (!run) begin
            s_d.div = '0;
            s_d.sck = 1'b0;
        end else if (s_q.div == TOP) begin
            s_d.div = '0;
            s_d.sck = ~s_q.sck;
            edge_o  = s_q.sck ? EDGE_TRAIL : EDGE_LEAD;
        end else begin
            s_d.div = s_q.div + DW'(1);
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) s_q <= '0;
        else        s_q <= s_d;
    end

    assign sck_o = s_q.sck;

    // R2: clock is parked low whenever no master transfer runs
    assert_sck_idle_low_R2: assert property (@(posedge clk) disable iff (!rst_n)
        !run |-> !s_q.sck);
endmodule

// File: rtl/spi_dr_slvin.sv
`timescale 1ns/1ps
module spi_dr_slvin
    import spi_dr_pkg::*;
#(
    parameter int SYNC = 2
) (
    input  logic  clk,
    input  logic  rst_n,
    input  logic  sck_i,
    input  logic  ss_n_i,
    input  logic  mosi_i,
    output logic  ss_act_o,
    output logic  mosi_o,
    output edge_e edge_o
);
    typedef struct packed {
        logic [SYNC:0] sck;
        logic [SYNC:0] ss;
        logic [SYNC:0] mosi;
    } sync_t;

    sync_t s_d, s_q;

    always_comb begin
        s_d.sck  = {s_q.sck[SYNC-1:0],  sck_i};
        s_d.ss   = {s_q.ss[SYNC-1:0],   ss_n_i};
        s_d.mosi = {s_q.mosi[SYNC-1:0], mosi_i};
        edge_o   = EDGE_NONE;
        if (!s_q.ss[SYNC-1]) begin
            if (s_q.sck[SYNC-1] && !s_q.sck[SYNC])      edge_o = EDGE_LEAD;
            else if (!s_q.sck[SYNC-1] && s_q.sck[SYNC]) edge_o = EDGE_TRAIL;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            s_q.sck  <= '0;
            s_q.ss   <= '1;
            s_q.mosi <= '0;
        end else begin
            s_q <= s_d;
        end
    end

    assign ss_act_o = ~s_q.ss[SYNC-1];
    assign mosi_o   = s_q.mosi[SYNC-1];
endmodule

// File: rtl/spi_dr_shift.sv
`timescale 1ns/1ps
module spi_dr_shift
    import spi_dr_pkg::*;
#(
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              master_i,
    input  logic              ss_act_i,
    input  edge_e             edge_i,
    input  logic              rx_i,
    input  logic              wr_i,
    input  logic [DATA_W-1:0] wr_data_i,
    input  logic              clr_i,
    output logic              tx_o,
    output logic              busy_o,
    output logic              spif_o,
    output logic              wcol_o,
    output logic [DATA_W-1:0] rd_o
);
    localparam int CW = $clog2(DATA_W);
    localparam logic [CW-1:0] LAST = CW'(DATA_W - 1);

    typedef struct packed {
        logic [CW-1:0] cnt;
        logic          samp;
        logic          busy;
        logic          spif;
        logic          wcol;
    } ctl_t;

    typedef struct packed {
        logic [DATA_W-1:0] sh;
        logic [DATA_W-1:0] rd;
    } dat_t;

    ctl_t c_d, c_q;
    dat_t d_d, d_q;

    always_comb begin
        c_d = c_q;
        d_d = d_q;
        c_d.spif = c_q.spif & ~clr_i;
        c_d.wcol = c_q.wcol & ~clr_i;
        if (!master_i && !ss_act_i) begin
            c_d.cnt  = '0;
            c_d.busy = 1'b0;
        end else if (edge_i == EDGE_LEAD) begin
            c_d.samp = rx_i;
            if (!master_i) c_d.busy = 1'b1;
        end else if (edge_i == EDGE_TRAIL && c_q.busy) begin
            d_d.sh = {d_q.sh[DATA_W-2:0], c_q.samp};
            if (c_q.cnt == LAST) begin
                c_d.cnt  = '0;
                c_d.busy = 1'b0;
                c_d.spif = 1'b1;
                d_d.rd   = {d_q.sh[DATA_W-2:0], c_q.samp};
            end else begin
                c_d.cnt = c_q.cnt + CW'(1);
            end
        end
        if (wr_i) begin
            if (c_q.busy) begin
                c_d.wcol = 1'b1;
            end else begin
                d_d.sh  = wr_data_i;
                c_d.cnt = '0;
                if (master_i) c_d.busy = 1'b1;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) c_q <= '0;
        else        c_q <= c_d;
    end

    always_ff @(posedge clk) begin
        d_q <= d_d;
    end

    assign tx_o   = d_q.sh[DATA_W-1];
    assign busy_o = c_q.busy;
    assign spif_o = c_q.spif;
    assign wcol_o = c_q.wcol;
    assign rd_o   = d_q.rd;

    // R5: a write during a transfer raises the collision flag
    assert_wcol_on_busy_write_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (c_q.busy && wr_i) |=> c_q.wcol);

    // R5: a colliding write leaves the shifter untouched
    assert_collision_keeps_shifter_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (c_q.busy && wr_i && edge_i == EDGE_NONE) |=> (d_q.sh == $past(d_q.sh)));

    // R4: final trailing edge sets the flag and ends the transfer
    assert_done_sets_flag_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (edge_i == EDGE_TRAIL && c_q.busy && c_q.cnt == LAST && (master_i || ss_act_i))
        |=> (c_q.spif && !c_q.busy));

    // R9: deselected slave holds no partial count
    assert_deselect_clears_count_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (!master_i && !ss_act_i) |=> (c_q.cnt == '0 && !c_q.busy));

    // R6: clear without a setting event drops the completion flag
    assert_clear_drops_flag_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (clr_i && !(edge_i == EDGE_TRAIL && c_q.busy)) |=> !c_q.spif);
endmodule

// File: rtl/spi_data_port.sv
`timescale 1ns/1ps
module spi_data_port
    import spi_dr_pkg::*;
#(
    parameter int DATA_W   = 8,
    parameter int DIV_HALF = 3,
    parameter int SYNC     = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              master_mode,
    input  logic              wr_stb,
    input  logic [DATA_W-1:0] wr_data,
    input  logic              clr_flags,
    output logic [DATA_W-1:0] rd_data,
    output logic              xfer_done,
    output logic              wr_coll,
    output logic              sck_out,
    output logic              mosi_out,
    input  logic              miso_in,
    input  logic              sck_in,
    input  logic              mosi_in,
    input  logic              ss_n,
    output logic              miso_out,
    output logic              miso_oe
);
    edge_e m_edge, s_edge, sel_edge;
    logic  busy, ss_act, mosi_s, tx, rx;

    spi_dr_mclk #(.DIV_HALF(DIV_HALF)) u_mclk (
        .clk    (clk),
        .rst_n  (rst_n),
        .run    (busy & master_mode),
        .sck_o  (sck_out),
        .edge_o (m_edge)
    );

    spi_dr_slvin #(.SYNC(SYNC)) u_slvin (
        .clk      (clk),
        .rst_n    (rst_n),
        .sck_i    (sck_in),
        .ss_n_i   (ss_n),
        .mosi_i   (mosi_in),
        .ss_act_o (ss_act),
        .mosi_o   (mosi_s),
        .edge_o   (s_edge)
    );

    assign sel_edge = master_mode ? m_edge : s_edge;
    assign rx       = master_mode ? miso_in : mosi_s;

    spi_dr_shift #(.DATA_W(DATA_W)) u_shift (
        .clk       (clk),
        .rst_n     (rst_n),
        .master_i  (master_mode),
        .ss_act_i  (ss_act),
        .edge_i    (sel_edge),
        .rx_i      (rx),
        .wr_i      (wr_stb),
        .wr_data_i (wr_data),
        .clr_i     (clr_flags),
        .tx_o      (tx),
        .busy_o    (busy),
        .spif_o    (xfer_done),
        .wcol_o    (wr_coll),
        .rd_o      (rd_data)
    );

    assign mosi_out = tx;
    assign miso_out = tx;
    assign miso_oe  = ~master_mode & ss_act;
endmodule

// File: tb/test_spi_data_port.sv
`timescale 1ns/1ps
module test_spi_data_port;
    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic master_mode = 1'b1;
    logic wr_stb = 1'b0;
    logic [7:0] wr_data = '0;
    logic clr_flags = 1'b0;
    logic [7:0] rd_data;
    logic xfer_done, wr_coll, sck_out, mosi_out, miso_out, miso_oe;
    logic sck_in = 1'b0;
    logic mosi_in = 1'b0;
    logic ss_n = 1'b1;
    logic [7:0] slv_tx = '0;
    logic miso_in;

    int total = 0;
    int bad = 0;
    bit finished = 0;

    logic [7:0] mosi_cap;
    int rise_cnt;
    realtime last_rise, period;

    always #2.5 clk = ~clk;

    spi_data_port i_spi_data_port (
        .clk(clk), .rst_n(rst_n), .master_mode(master_mode),
        .wr_stb(wr_stb), .wr_data(wr_data), .clr_flags(clr_flags),
        .rd_data(rd_data), .xfer_done(xfer_done), .wr_coll(wr_coll),
        .sck_out(sck_out), .mosi_out(mosi_out), .miso_in(miso_in),
        .sck_in(sck_in), .mosi_in(mosi_in), .ss_n(ss_n),
        .miso_out(miso_out), .miso_oe(miso_oe)
    );

    assign miso_in = slv_tx[7];

    always @(posedge sck_out) begin
        mosi_cap = {mosi_cap[6:0], mosi_out};
        if (rise_cnt > 0) period = $realtime - last_rise;
        last_rise = $realtime;
        rise_cnt++;
    end

    always @(negedge sck_out) slv_tx = {slv_tx[6:0], 1'b0};

    task automatic check(input bit ok, input string req, input int act, input int exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s act=%0h exp=%0h", req, act, exp);
        end
    endtask

    task automatic write_byte(input logic [7:0] b);
        @(negedge clk); wr_stb = 1'b1; wr_data = b;
        @(negedge clk); wr_stb = 1'b0;
    endtask

    task automatic clear_flags();
        @(negedge clk); clr_flags = 1'b1;
        @(negedge clk); clr_flags = 1'b0;
    endtask

    task automatic wait_done();
        for (int i = 0; i < 400; i++) begin
            @(negedge clk);
            if (xfer_done) break;
        end
    endtask

    task automatic t_reset();
        check(xfer_done == 1'b0, "R7 reset done flag", xfer_done, 0);
        check(wr_coll == 1'b0, "R7 reset coll flag", wr_coll, 0);
        check(sck_out == 1'b0, "R2 idle sck low", sck_out, 0);
        check(miso_oe == 1'b0, "R8 oe off when deselected", miso_oe, 0);
    endtask

    task automatic t_master_xfer(input logic [7:0] tx, input logic [7:0] rx, input logic [7:0] prev);
        master_mode = 1'b1;
        clear_flags();
        rise_cnt = 0;
        slv_tx = rx;
        write_byte(tx);
        repeat (12) @(negedge clk);
        check(rd_data == prev, "R3 old byte held mid transfer", rd_data, prev);
        check(xfer_done == 1'b0, "R4 flag clear mid transfer", xfer_done, 0);
        wait_done();
        repeat (4) @(negedge clk);
        check(xfer_done == 1'b1, "R4 done flag", xfer_done, 1);
        check(mosi_cap == tx, "R1 mosi byte msb first", mosi_cap, tx);
        check(rd_data == rx, "R3 received byte", rd_data, rx);
        check(rise_cnt == 8, "R2 rising edge count", rise_cnt, 8);
        check(int'(period) == 30, "R2 sck period ns", int'(period), 30);
        check(sck_out == 1'b0, "R2 sck parked low", sck_out, 0);
        check(wr_coll == 1'b0, "R5 no collision", wr_coll, 0);
        repeat (10) @(negedge clk);
        check(xfer_done == 1'b1, "R4 flag sticky", xfer_done, 1);
        clear_flags();
        check(xfer_done == 1'b0, "R6 clear done", xfer_done, 0);
    endtask

    task automatic t_master_collision();
        master_mode = 1'b1;
        clear_flags();
        rise_cnt = 0;
        slv_tx = 8'h96;
        write_byte(8'hC3);
        repeat (10) @(negedge clk);
        write_byte(8'h18);
        check(wr_coll == 1'b1, "R5 collision flag", wr_coll, 1);
        wait_done();
        repeat (4) @(negedge clk);
        check(mosi_cap == 8'hC3, "R5 original byte sent", mosi_cap, 8'hC3);
        check(rd_data == 8'h96, "R5 receive unaffected", rd_data, 8'h96);
        check(rise_cnt == 8, "R5 length unchanged", rise_cnt, 8);
        clear_flags();
        check(wr_coll == 1'b0, "R6 clear coll", wr_coll, 0);
    endtask

    task automatic t_set_beats_clear();
        master_mode = 1'b1;
        slv_tx = 8'h00;
        write_byte(8'h11);
        repeat (6) @(negedge clk);
        @(negedge clk); wr_stb = 1'b1; wr_data = 8'h22; clr_flags = 1'b1;
        @(negedge clk); wr_stb = 1'b0; clr_flags = 1'b0;
        check(wr_coll == 1'b1, "R6 set wins over clear", wr_coll, 1);
        wait_done();
        repeat (4) @(negedge clk);
        clear_flags();
    endtask

    task automatic t_reset_keeps_data(input logic [7:0] exp);
        @(negedge clk); rst_n = 1'b0;
        repeat (3) @(negedge clk); rst_n = 1'b1;
        @(negedge clk);
        check(rd_data == exp, "R7 data survives reset", rd_data, exp);
        check(xfer_done == 1'b0, "R7 flags cleared by reset", xfer_done, 0);
    endtask

    task automatic slave_shift(input logic [7:0] mb, input int n, inout logic [7:0] cap);
        for (int i = 0; i < n; i++) begin
            mosi_in = mb[7-i];
            #40;
            cap = {cap[6:0], miso_out};
            sck_in = 1'b1;
            #40;
            sck_in = 1'b0;
        end
        #40;
    endtask

    task automatic t_slave_xfer(input logic [7:0] ld, input logic [7:0] mb);
        logic [7:0] cap = '0;
        master_mode = 1'b0;
        clear_flags();
        write_byte(ld);
        check(wr_coll == 1'b0, "R10 idle slave write no collision", wr_coll, 0);
        ss_n = 1'b0;
        #40;
        check(miso_oe == 1'b1, "R8 oe on when selected", miso_oe, 1);
        slave_shift(mb, 8, cap);
        ss_n = 1'b1;
        #60;
        check(miso_oe == 1'b0, "R8 oe off after deselect", miso_oe, 0);
        check(cap == ld, "R8 miso byte msb first", cap, ld);
        check(rd_data == mb, "R3 slave received byte", rd_data, mb);
        check(xfer_done == 1'b1, "R4 slave done flag", xfer_done, 1);
        clear_flags();
    endtask

    task automatic t_slave_unselected(input logic [7:0] prev);
        logic [7:0] cap = '0;
        master_mode = 1'b0;
        clear_flags();
        slave_shift(8'h5A, 8, cap);
        #60;
        check(xfer_done == 1'b0, "R8 no shift while deselected", xfer_done, 0);
        check(rd_data == prev, "R8 data kept while deselected", rd_data, prev);
    endtask

    task automatic t_slave_abort(input logic [7:0] prev);
        logic [7:0] cap = '0;
        master_mode = 1'b0;
        clear_flags();
        ss_n = 1'b0; #40;
        slave_shift(8'hF0, 3, cap);
        ss_n = 1'b1; #80;
        check(xfer_done == 1'b0, "R9 abort sets no flag", xfer_done, 0);
        check(rd_data == prev, "R9 abort keeps data", rd_data, prev);
        ss_n = 1'b0; #40;
        slave_shift(8'h3D, 8, cap);
        ss_n = 1'b1; #60;
        check(rd_data == 8'h3D, "R9 restart from bit 0", rd_data, 8'h3D);
        check(xfer_done == 1'b1, "R9 restart completes", xfer_done, 1);
        clear_flags();
    endtask

    task automatic t_slave_collision();
        logic [7:0] cap = '0;
        master_mode = 1'b0;
        clear_flags();
        write_byte(8'hA7);
        ss_n = 1'b0; #40;
        slave_shift(8'h6C, 2, cap);
        write_byte(8'h00);
        check(wr_coll == 1'b1, "R10 write after first edge collides", wr_coll, 1);
        slave_shift(8'h6C << 2, 6, cap);
        ss_n = 1'b1; #60;
        check(cap == 8'hA7, "R5 slave original byte kept", cap, 8'hA7);
        check(rd_data == 8'h6C, "R5 slave receive unaffected", rd_data, 8'h6C);
        clear_flags();
    endtask

    initial begin
        repeat (4) @(negedge clk);
        t_reset();
        rst_n = 1'b1;
        repeat (2) @(negedge clk);
        t_master_xfer(8'hA5, 8'h3C, rd_data);
        t_master_xfer(8'h80, 8'h01, 8'h3C);
        t_master_xfer(8'hFF, 8'h00, 8'h01);
        t_master_collision();
        t_set_beats_clear();
        t_master_xfer(8'h4E, 8'hB2, 8'h00);
        t_reset_keeps_data(8'hB2);
        t_slave_xfer(8'h9B, 8'h27);
        t_slave_unselected(8'h27);
        t_slave_abort(8'h27);
        t_slave_collision();
        if (!finished) begin
            finished = 1;
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        #500000;
        if (!finished) begin
            finished = 1;
            total++;
            bad++;
            $display("FAIL watchdog act=0 exp=1");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end
endmodule